// File: doc/BRIEF.md
# Serial EEPROM Device Model (Three-Wire Command Slave)

This block models the device side of a three-wire serial memory with a chip-select line, a serial clock and one data input. It runs in the system clock domain and takes `cs`, `sk` and `di` already synchronised. It finds the rising edges of `sk` by comparing against a registered copy. A frame opens with a start bit. Then come a two-bit opcode, an address and, for write-type commands, a data word. The block reads words out serially and keeps an erase/write enable latch. It performs single-word and whole-array erase and write, and it reports ready/busy on its data output.

The `org` input selects the word organisation. When high, the array is 16 bits wide with `ADDR_W` address bits. When low, it is 8 bits wide with `ADDR_W+1` address bits, and the lowest address bit picks a byte lane of the stored 16-bit word. An unconnected select should be tied high at integration. Storage is two byte-wide arrays that can map onto block RAM. A down-counter of `PROG_CYCLES` system clocks stands in for the self-timed programming cycle. Bulk commands sweep the array one word per clock inside the busy window. The tri-state output is modelled as `do_o` plus an enable `do_oe`, and both are registered.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While `cs` is high and no command is open, zeros sampled on rising `sk` edges are ignored; the first 1 sampled is the start bit.
- R2: After the start bit come 2 opcode bits, then `ADDR_W` address bits when `org`=1 or `ADDR_W+1` when `org`=0, all MSB first; in the 8-bit organisation address bit 0 = 1 selects the upper byte of the stored word and 0 the lower byte.
- R3: Opcode 10 reads, 01 writes one word, 11 erases one word; opcode 00 is decoded by the two most significant address bits: 11 enables programming, 00 disables it, 10 erases the whole array, 01 writes one data word into the whole array.
- R4: On a read, the `sk` edge that clocks in the last address bit makes DO drive a 0 dummy bit; each following rising edge presents the next data bit, MSB first; after the last data bit DO stays 0.
- R5: After reset programming is disabled: erase and write commands complete their frame but change nothing and show no busy status; reads work in either state.
- R6: The enable latch stays set until a disable command, which blocks programming again.
- R7: Programming starts on the `sk` edge that clocks in the final bit of its frame (last address bit for single erase and array erase, last data bit for single write and array write); dropping `cs` earlier aborts the command and leaves the array unchanged.
- R8: Single erase sets the addressed word (or byte) to all ones, array erase sets every word to all ones, array write stores the pattern in every word, and a write needs no prior erase.
- R9: From the start of programming, with `cs` high DO shows 0 (busy) for at least `PROG_CYCLES` clocks and then 1 (ready); toggling `cs` during programming does not disturb it.
- R10: `do_oe` is 0 whenever `cs` is low.
- R11: Once ready is shown, a 1 clocked into DI returns DO to high impedance and also acts as the start bit of a new command.
- R12: While programming runs, `sk` and `di` are ignored: no start bit is taken and no command is decoded.
- R13: A write in the 8-bit organisation changes only the selected byte lane of the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, synchronised |
| sk | input | 1 | Serial clock, synchronised; rising edges are active |
| di | input | 1 | Serial data in, synchronised |
| org | input | 1 | Organisation select: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data / ready-busy status |
| do_oe | output | 1 | Output enable for `do_o`; 0 stands for high impedance |

## Verification
A table of mixed-organisation words is written and read back: all zeros, the top address, alternating patterns, and two bytes that share one stored word. This separates lane selection and the longer 8-bit address frame from plain 16-bit access. Directed frames then check the following: leading zeros before the start bit, a write aborted one data bit early, and writes attempted before enable and after disable. They also check array erase and array write read back in both organisations, and stray `sk`/`di` activity and `cs` toggling during busy. The last case has the ready-clearing 1 doubling as a start bit, where a wrong bit count shows up as misaligned read data. Busy duration is measured against `PROG_CYCLES`, and the read tail is checked for the trailing zero.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    P_ERASE = 2'd0,
    P_WRITE = 2'd1,
    P_ERAL  = 2'd2,
    P_WRAL  = 2'd3
  } prog_kind_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPC  = 3'd1,
    S_ADDR = 3'd2,
    S_DATA = 3'd3,
    S_READ = 3'd4,
    S_DONE = 3'd5
  } dec_state_t;

endpackage

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [15:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [15:0]       rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_hi [DEPTH];
  logic [7:0] mem_lo [DEPTH];

  always_ff @(posedge clk) begin
    if (we_hi) mem_hi[waddr] <= wdata[15:8];
    rdata[15:8] <= mem_hi[raddr];
  end

  always_ff @(posedge clk) begin
    if (we_lo) mem_lo[waddr] <= wdata[7:0];
    rdata[7:0] <= mem_lo[raddr];
  end

endmodule

// File: rtl/mw_cmd_decode.sv
module mw_cmd_decode
  import mw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              org,
  input  logic              busy,
  input  logic [15:0]       rdata,
  output logic              go,
  output prog_kind_t        kind,
  output logic [ADDR_W:0]   go_addr,
  output logic [15:0]       go_data,
  output logic              start,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_act,
  output logic              rd_do
);
  localparam int AW_MAX = ADDR_W + 1;
  localparam int CNT_MAX = (AW_MAX > WORD_W) ? AW_MAX : WORD_W;
  localparam int CW = $clog2(CNT_MAX + 1);

  dec_state_t       st;
  logic             sk_q;
  logic             en_q;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    rd_cnt;
  logic [1:0]       opc;
  logic [ADDR_W:0]  addr_sh;
  logic [15:0]      data_sh;
  logic             rd_lane;

  logic             edge_ok;
  logic [CW-1:0]    aw_last;
  logic [CW-1:0]    dw_last;
  logic [ADDR_W:0]  a_next;
  logic [15:0]      d_next;
  logic [1:0]       top2;
  logic [7:0]       rd_byte;
  logic [15:0]      rd_vec;
  logic [3:0]       rd_idx;

  always_comb begin
    edge_ok = cs & sk & ~sk_q & ~busy;
    aw_last = org ? CW'(ADDR_W - 1) : CW'(ADDR_W);
    dw_last = org ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
    a_next  = {addr_sh[ADDR_W-1:0], di};
    d_next  = {data_sh[14:0], di};
    top2    = org ? a_next[ADDR_W-1 -: 2] : a_next[ADDR_W -: 2];
    rd_byte = rd_lane ? rdata[15:8] : rdata[7:0];
    rd_vec  = org ? rdata : {rd_byte, 8'h00};
    rd_idx  = 4'(4'd15 - rd_cnt[3:0]);
    rd_act  = (st == S_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) sk_q <= 1'b0;
    else     sk_q <= sk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      en_q    <= 1'b0;
      cnt     <= '0;
      rd_cnt  <= '0;
      opc     <= '0;
      addr_sh <= '0;
      data_sh <= '0;
      rd_lane <= 1'b0;
      rd_do   <= 1'b0;
      go      <= 1'b0;
      start   <= 1'b0;
      kind    <= P_ERASE;
      go_addr <= '0;
      go_data <= '0;
      raddr   <= '0;
    end else begin
      go    <= 1'b0;
      start <= 1'b0;
      if (!cs) begin
        st      <= S_IDLE;
        cnt     <= '0;
        opc     <= '0;
        addr_sh <= '0;
        data_sh <= '0;
        rd_do   <= 1'b0;
      end else if (edge_ok) begin
        unique case (st)
          S_IDLE: begin
            if (di) begin
              st      <= S_OPC;
              start   <= 1'b1;
              cnt     <= '0;
              addr_sh <= '0;
              data_sh <= '0;
            end
          end
          S_OPC: begin
            opc <= {opc[0], di};
            if (cnt == CW'(1)) begin
              cnt <= '0;
              st  <= S_ADDR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ADDR: begin
            addr_sh <= a_next;
            if (cnt == aw_last) begin
              cnt     <= '0;
              go_addr <= a_next;
              unique case (opc)
                2'b10: begin
                  raddr   <= org ? a_next[ADDR_W-1:0] : a_next[ADDR_W:1];
                  rd_lane <= a_next[0];
                  rd_do   <= 1'b0;
                  rd_cnt  <= '0;
                  st      <= S_READ;
                end
                2'b01: begin
                  kind <= P_WRITE;
                  st   <= S_DATA;
                end
                2'b11: begin
                  kind <= P_ERASE;
                  go   <= en_q;
                  st   <= en_q ? S_IDLE : S_DONE;
                end
                default: begin
                  unique case (top2)
                    2'b11: begin
                      en_q <= 1'b1;
                      st   <= S_DONE;
                    end
                    2'b00: begin
                      en_q <= 1'b0;
                      st   <= S_DONE;
                    end
                    2'b10: begin
                      kind <= P_ERAL;
                      go   <= en_q;
                      st   <= en_q ? S_IDLE : S_DONE;
                    end
                    default: begin
                      kind <= P_WRAL;
                      st   <= S_DATA;
                    end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            data_sh <= d_next;
            if (cnt == dw_last) begin
              cnt     <= '0;
              go      <= en_q;
              go_data <= d_next;
              st      <= en_q ? S_IDLE : S_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_READ: begin
            if (rd_cnt <= dw_last) begin
              rd_do  <= rd_vec[rd_idx];
              rd_cnt <= rd_cnt + 1'b1;
            end else begin
              rd_do <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!start && !go));

endmodule

// File: rtl/mw_prog_seq.sv
module mw_prog_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              org,
  input  logic              go,
  input  prog_kind_t        kind,
  input  logic [ADDR_W:0]   go_addr,
  input  logic [15:0]       go_data,
  input  logic              start,
  output logic              busy,
  output logic              stat_show,
  output logic              we_hi,
  output logic              we_lo,
  output logic [ADDR_W-1:0] waddr,
  output logic [15:0]       wdata
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LAST_WORD = '1;

  logic [TW-1:0]     timer;
  logic              sweeping;
  logic              bulk;
  logic              hi_en;
  logic              lo_en;
  logic [ADDR_W-1:0] ptr;
  logic [15:0]       pat;
  logic              is_bulk;
  logic              is_erase;

  always_comb begin
    is_bulk  = (kind == P_ERAL) || (kind == P_WRAL);
    is_erase = (kind == P_ERASE) || (kind == P_ERAL);
    we_hi    = sweeping & hi_en;
    we_lo    = sweeping & lo_en;
    waddr    = ptr;
    wdata    = pat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      timer    <= '0;
      sweeping <= 1'b0;
      bulk     <= 1'b0;
      hi_en    <= 1'b0;
      lo_en    <= 1'b0;
      ptr      <= '0;
      pat      <= '0;
    end else if (go && !busy) begin
      busy     <= 1'b1;
      timer    <= TW'(PROG_CYCLES - 1);
      sweeping <= 1'b1;
      bulk     <= is_bulk;
      ptr      <= is_bulk ? '0 : (org ? go_addr[ADDR_W-1:0] : go_addr[ADDR_W:1]);
      pat      <= is_erase ? 16'hFFFF : (org ? go_data : {go_data[7:0], go_data[7:0]});
      hi_en    <= org | is_bulk | go_addr[0];
      lo_en    <= org | is_bulk | ~go_addr[0];
    end else if (busy) begin
      if (timer != '0) timer <= timer - 1'b1;
      if (sweeping) begin
        if (!bulk || ptr == LAST_WORD) sweeping <= 1'b0;
        else                           ptr <= ptr + 1'b1;
      end
      if (timer == '0 && !sweeping) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              stat_show <= 1'b0;
    else if (go && !busy)                 stat_show <= 1'b1;
    else if (!busy && (start || !cs))     stat_show <= 1'b0;
  end

  logic [31:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  // R7
  go_starts_busy_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

  // R8
  sweep_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !sweeping);

  // R9
  busy_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len >= 32'(PROG_CYCLES)));

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  logic              go;
  prog_kind_t        kind;
  logic [ADDR_W:0]   go_addr;
  logic [15:0]       go_data;
  logic              start;
  logic [ADDR_W-1:0] raddr;
  logic              rd_act;
  logic              rd_do;
  logic [15:0]       rdata;
  logic              busy;
  logic              stat_show;
  logic              we_hi;
  logic              we_lo;
  logic [ADDR_W-1:0] waddr;
  logic [15:0]       wdata;

  mw_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
    .busy(busy), .rdata(rdata), .go(go), .kind(kind),
    .go_addr(go_addr), .go_data(go_data), .start(start),
    .raddr(raddr), .rd_act(rd_act), .rd_do(rd_do)
  );

  mw_prog_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .cs(cs), .org(org), .go(go), .kind(kind),
    .go_addr(go_addr), .go_data(go_data), .start(start),
    .busy(busy), .stat_show(stat_show), .we_hi(we_hi), .we_lo(we_lo),
    .waddr(waddr), .wdata(wdata)
  );

  mw_word_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we_hi(we_hi), .we_lo(we_lo), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      do_o  <= 1'b0;
      do_oe <= 1'b0;
    end else begin
      do_oe <= cs & (stat_show | rd_act);
      do_o  <= cs & (stat_show ? ~busy : rd_do);
    end
  end

  // R10
  hiz_cs_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !do_oe);

  // R12
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (we_hi || we_lo) |-> busy);

endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int AW   = 6;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst, cs, sk, di, org;
  logic do_o, do_oe;
  int   n_run = 0, n_fail = 0, cyc = 0;
  bit   done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  mw_eeprom_slave #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  // org, 7-bit address, 16-bit data
  localparam logic [23:0] VEC [0:5] = '{
    {1'b1, 7'd3,  16'h1234},
    {1'b1, 7'd10, 16'hBEEF},
    {1'b1, 7'd63, 16'h8001},
    {1'b1, 7'd0,  16'h0000},
    {1'b0, 7'd9,  16'h005A},
    {1'b0, 7'd8,  16'h00C3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic so, output logic se);
    di = b;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    so = do_o;
    se = do_oe;
    sk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input int n, input logic [31:0] v);
    logic so, se;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], so, se);
  endtask

  task automatic cs_cycle();
    cs = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
    cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic int awid(input logic o);
    return o ? AW : AW + 1;
  endfunction

  function automatic logic [31:0] hdr(input logic o, input logic [1:0] op, input int a);
    int w = awid(o);
    return (32'd1 << (w + 2)) | (32'(op) << w) | 32'(a);
  endfunction

  task automatic wait_ready(output int t);
    int n = 0;
    while (!(do_oe && do_o) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  // returns busy_seen (busy on final bit) and cycles from final-bit sample to ready
  task automatic prog(input logic o, input logic [1:0] op, input int a, input bit has_d,
                      input logic [15:0] d, output logic busy_seen, output int dur);
    logic so, se;
    int   w = awid(o), dw = o ? 16 : 8, t0, t1;
    logic [31:0] h = hdr(o, op, a);
    cs_cycle();
    if (has_d) begin
      send(w + 3, h);
      send(dw - 1, 32'(d) >> 1);
      pulse(d[0], so, se);
    end else begin
      send(w + 2, h >> 1);
      pulse(h[0], so, se);
    end
    busy_seen = se && !so;
    t0 = cyc;
    dur = 0;
    if (busy_seen) begin
      wait_ready(t1);
      dur = t1 - t0;
    end
    cs = 1'b0;
  endtask

  task automatic rd(input logic o, input int a, input int lead, output logic [15:0] val,
                    output logic dum_ok, output logic tail0);
    logic so, se;
    int   w = awid(o), dw = o ? 16 : 8;
    logic [31:0] h = hdr(o, 2'b10, a);
    cs_cycle();
    for (int i = 0; i < lead; i++) pulse(1'b0, so, se);
    send(w + 2, h >> 1);
    pulse(h[0], so, se);
    dum_ok = se && !so;
    val = '0;
    for (int i = 0; i < dw; i++) begin
      pulse(1'b0, so, se);
      val = {val[14:0], so};
    end
    pulse(1'b0, so, se);
    tail0 = se && !so;
    cs = 1'b0;
  endtask

  initial begin
    logic [15:0] v, exp;
    logic        dum, tl, bs, so, se;
    int          dur, t0, t1;
    rst = 1'b1; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!do_oe && !do_o, "R10 reset idle", {do_oe, do_o}, 0);

    // R5: write before any enable shows no busy
    prog(1'b1, 2'b01, 5, 1, 16'h0000, bs, dur);
    chk(!bs, "R5 write disabled after reset", bs, 0);

    // enable, erase whole array
    prog(1'b1, 2'b00, 3 << (AW - 2), 0, 0, bs, dur);
    chk(!bs, "R3 enable shows no status", bs, 0);
    prog(1'b1, 2'b00, 2 << (AW - 2), 0, 0, bs, dur);
    chk(bs, "R9 busy after array erase", bs, 1);
    foreach (VEC[i]) begin
      rd(1'b1, i * 11 + 5, 0, v, dum, tl);
      chk(v == 16'hFFFF, "R8 array erase", v, 16'hFFFF);
    end

    // disable, then write has no effect
    org = 1'b0;
    prog(1'b0, 2'b00, 0, 0, 0, bs, dur);
    org = 1'b1;
    prog(1'b1, 2'b01, 20, 1, 16'h0000, bs, dur);
    chk(!bs, "R6 write blocked after disable", bs, 0);
    rd(1'b1, 20, 0, v, dum, tl);
    chk(v == 16'hFFFF, "R5 R6 word unchanged while disabled", v, 16'hFFFF);

    // re-enable in 8-bit frame
    org = 1'b0;
    prog(1'b0, 2'b00, 3 << (AW - 1), 0, 0, bs, dur);

    // table walk: write then read back
    for (int i = 0; i < 6; i++) begin
      org = VEC[i][23];
      prog(VEC[i][23], 2'b01, int'(VEC[i][22:16]), 1, VEC[i][15:0], bs, dur);
      chk(bs, "R7 write starts on last data bit", bs, 1);
      rd(VEC[i][23], int'(VEC[i][22:16]), 0, v, dum, tl);
      exp = VEC[i][23] ? VEC[i][15:0] : {8'h00, VEC[i][7:0]};
      chk(dum, "R4 dummy zero", dum, 1);
      chk(v == exp, "R2 R3 R8 readback", v, exp);
    end
    org = 1'b1;
    rd(1'b1, 4, 0, v, dum, tl);
    chk(v == 16'h5AC3, "R13 byte lanes merged", v, 16'h5AC3);
    chk(tl, "R4 trailing zero after data", tl, 1);

    // R1: leading zeros before start bit
    rd(1'b1, 3, 3, v, dum, tl);
    chk(v == 16'h1234, "R1 leading zeros ignored", v, 16'h1234);

    // R7: abort a write one bit early
    cs_cycle();
    send(AW + 3, hdr(1'b1, 2'b01, 10));
    send(15, 32'h0000);
    cs = 1'b0;
    rd(1'b1, 10, 0, v, dum, tl);
    chk(v == 16'hBEEF, "R7 aborted write", v, 16'hBEEF);

    // single erase
    prog(1'b1, 2'b11, 3, 0, 0, bs, dur);
    chk(bs, "R7 erase starts on last address bit", bs, 1);
    rd(1'b1, 3, 0, v, dum, tl);
    chk(v == 16'hFFFF, "R8 single erase", v, 16'hFFFF);
    rd(1'b1, 10, 0, v, dum, tl);
    chk(v == 16'hBEEF, "R8 neighbour untouched", v, 16'hBEEF);

    // busy behaviour
    cs_cycle();
    send(AW + 3, hdr(1'b1, 2'b01, 7));
    send(15, 32'h0F0F >> 1);
    pulse(1'b1, so, se);
    t0 = cyc;
    chk(se && !so, "R9 busy shown", {se, so}, 2);
    cs = 1'b0;
    repeat (2) @(negedge clk);
    chk(!do_oe, "R10 hi-z during busy with cs low", do_oe, 0);
    cs = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe && !do_o, "R9 busy kept across cs toggle", {do_oe, do_o}, 2);
    pulse(1'b1, so, se);
    pulse(1'b1, so, se);
    chk(se && !so, "R12 busy while sk toggles", {se, so}, 2);
    wait_ready(t1);
    chk((t1 - t0) >= PROG - 4 && (t1 - t0) <= PROG + 2, "R9 busy duration", t1 - t0, PROG);
    repeat (3) @(negedge clk);
    chk(do_oe && do_o, "R12 ready held, no command taken", {do_oe, do_o}, 3);
    pulse(1'b1, so, se);
    chk(!se, "R11 start bit clears status", se, 0);
    send(2 + AW - 1, {2'b10, 6'd7} >> 1);
    pulse(1'b1, so, se);
    chk(se && !so, "R11 start bit reused dummy", {se, so}, 2);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0, so, se);
      v = {v[14:0], so};
    end
    cs = 1'b0;
    chk(v == 16'h0F0F, "R11 R12 read after reused start", v, 16'h0F0F);

    // array write, 16 then 8 bit
    prog(1'b1, 2'b00, 1 << (AW - 2), 1, 16'hA5C3, bs, dur);
    rd(1'b1, 33, 0, v, dum, tl);
    chk(v == 16'hA5C3, "R8 array write", v, 16'hA5C3);
    org = 1'b0;
    rd(1'b0, 67, 0, v, dum, tl);
    chk(v == 16'h00A5, "R2 upper lane", v, 16'h00A5);
    rd(1'b0, 66, 0, v, dum, tl);
    chk(v == 16'h00C3, "R2 lower lane", v, 16'h00C3);
    prog(1'b0, 2'b00, 1 << (AW - 1), 1, 16'h003C, bs, dur);
    org = 1'b1;
    rd(1'b1, 5, 0, v, dum, tl);
    chk(v == 16'h3C3C, "R8 array write 8-bit", v, 16'h3C3C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule